// File: doc/BRIEF.md
# Serial Step-Attenuator Control Interface

This block is the digital front end of a 6-bit step attenuator. It receives an 8-bit control word over a four-wire serial link made of a serial clock, a data line and an active-low select. It also has an active-low device reset pin. A fast system clock samples all of these pins. Each pin passes through a two-flop synchroniser, and edges are detected on the synchronised copies.

Data enters a shift register on each rising edge of the serial clock while select is low. The first bit on the wire ends up in the lowest position. When select rises, the six attenuation bits of the word move into the active register, and a one-cycle strobe marks the load.

The serial output repeats the input stream eight serial clocks later, so several parts can share one select line in a chain. The serial output is held low while the part is deselected. The attenuation code is active-low: a 1 bypasses its step, so an all-zero code is the largest attenuation.

Top module: `atten_ctrl_slave`

## Requirements
- R1: While and after the system reset `rst_n`, with no serial activity, `atten_code` is 0, `ser_dout` is 0 and `word_load` is 0.
- R2: Bits are shifted in on rising edges of `ser_clk` while `ser_cs_n` is low, first bit first. Wire bits 0 and 1 are reserved. Wire bits 2 to 7 become `atten_code[0]` to `atten_code[5]`, so after 8 clocks and a select rise, `atten_code` equals the word shifted right by two.
- R3: Rising edges of `ser_clk` while `ser_cs_n` is high leave the shift register unchanged. A later select pulse with no clocks re-latches the earlier word.
- R4: `atten_code` changes only on a rising edge of `ser_cs_n` or on a device reset. The new code appears on the third system clock edge that samples the pin high.
- R5: `atten_code` carries the control bits unmodified. Bit 5 controls the 16 dB step and bit 0 the 0.5 dB step, and a 1 bypasses that step. Word 0xFF gives code 0x3F (minimum attenuation), and word 0x80 gives 0x20 (only the 16 dB step bypassed).
- R6: While select is low, `ser_dout` shows the data bit that entered eight serial clocks earlier. A downstream part sampling on serial clocks 9 to 16 receives the first word of a 16-bit burst. `ser_dout` is 0 while select is high.
- R7: A falling edge on `ser_rst_n` clears the shift register and forces `atten_code` to 0. A following select pulse with no clocks latches the zero word. If both events come in the same cycle, the reset wins.
- R8: `word_load` pulses for exactly one system cycle for each latch caused by a select rise.
- R9: A select rise after fewer than 8 serial clocks latches the shift register as it stands, with no length check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ser_clk | input | 1 | Serial clock pin |
| ser_din | input | 1 | Serial data pin |
| ser_cs_n | input | 1 | Active-low select pin; its rising edge loads the word |
| ser_rst_n | input | 1 | Active-low device reset pin; acts on its falling edge |
| ser_dout | output | 1 | Serial data out, delayed by 8 serial clocks, low when deselected |
| atten_code | output | 6 | Active attenuation control bits (1 = step bypassed) |
| word_load | output | 1 | One-cycle strobe on each select-driven load |

## Verification
Several distinct words are written: an asymmetric pattern that exposes any reversal of bit order, all-ones, and a lone 16 dB bit. Together they separate a correct field position from an off-by-one shift. A 16-bit burst checks that the serial output delivers the first word exactly on clocks 9 to 16 while the second word stays behind. Clocks sent while deselected, a 3-bit short word, and a device reset followed by an empty select pulse each leave a different expected code. This distinguishes ignored edges, partial shifts and clearing.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int unsigned WORD_BITS  = 8;
  localparam int unsigned RSV_BITS   = 2;
  localparam int unsigned SYNC_DEPTH = 2;

  // positions of the pins inside the synchronised pin vector
  localparam int unsigned PIN_DIN   = 0;
  localparam int unsigned PIN_SCLK  = 1;
  localparam int unsigned PIN_CSN   = 2;
  localparam int unsigned PIN_RSTN  = 3;
  localparam int unsigned PIN_COUNT = 4;

  // idle pin levels: reset pin high, select high, clock low, data low
  localparam logic [PIN_COUNT-1:0] PIN_IDLE = 4'b1100;
endpackage

// File: rtl/atten_pin_sync.sv
module atten_pin_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/atten_edge_det.sv
module atten_edge_det #(
  parameter int unsigned WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL   = '0,
  parameter logic [WIDTH-1:0] FALL_MASK = '0  // 1: detect falling edge on that bit
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sig_i,
  output logic [WIDTH-1:0] edge_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= sig_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (FALL_MASK[i]) begin : g_fall
      assign edge_o[i] = prev_q[i] & ~sig_i[i];
    end else begin : g_rise
      assign edge_o[i] = ~prev_q[i] & sig_i[i];
    end
  end
endmodule

// File: rtl/atten_shift_path.sv
module atten_shift_path #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              din,
  input  logic              drive_en,
  output logic [WORD_W-1:0] word_o,
  output logic              sdo_o
);
  logic [WORD_W-1:0] sreg_q, sreg_d;

  // newest bit enters at the top, oldest bit leaves at position 0
  always_comb begin
    sreg_d = sreg_q;
    if (clear)         sreg_d = '0;
    else if (shift_en) sreg_d = {din, sreg_q[WORD_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else        sreg_q <= sreg_d;
  end

  assign word_o = sreg_q;
  assign sdo_o  = drive_en & sreg_q[0];
endmodule

// File: rtl/atten_active_reg.sv
module atten_active_reg #(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  logic [CODE_W-1:0] load_word,
  output logic [CODE_W-1:0] code_o,
  output logic              stb_o
);
  logic [CODE_W-1:0] code_q, code_d;
  logic              stb_q, stb_d;

  always_comb begin
    code_d = code_q;
    stb_d  = 1'b0;
    if (clear) begin
      code_d = '0;
    end else if (load) begin
      code_d = load_word;
      stb_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      stb_q  <= stb_d;
    end
  end

  assign code_o = code_q;
  assign stb_o  = stb_q;
endmodule

// File: rtl/atten_ctrl_slave.sv
module atten_ctrl_slave
  import atten_pkg::*;
#(
  parameter int unsigned WORD_W      = WORD_BITS,
  parameter int unsigned RSV_W       = RSV_BITS,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ser_clk,
  input  logic                    ser_din,
  input  logic                    ser_cs_n,
  input  logic                    ser_rst_n,
  output logic                    ser_dout,
  output logic [WORD_W-RSV_W-1:0] atten_code,
  output logic                    word_load
);
  localparam int unsigned CODE_W = WORD_W - RSV_W;
  localparam int unsigned EDGE_W = PIN_COUNT - 1;

  logic [PIN_COUNT-1:0] pin_raw, pin_s;
  logic [EDGE_W-1:0]    edge_hit;
  logic                 sclk_rise, cs_rise, rst_fall, cs_n_s, shift_en;
  logic [WORD_W-1:0]    sreg_word;

  assign pin_raw = {ser_rst_n, ser_cs_n, ser_clk, ser_din};

  atten_pin_sync #(
    .WIDTH  (PIN_COUNT),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(pin_raw),
    .sync_o (pin_s)
  );

  // edge bits: [0] clock rise, [1] select rise, [2] reset-pin fall
  atten_edge_det #(
    .WIDTH    (EDGE_W),
    .RST_VAL  (PIN_IDLE[PIN_COUNT-1:1]),
    .FALL_MASK(3'b100)
  ) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_i (pin_s[PIN_COUNT-1:1]),
    .edge_o(edge_hit)
  );

  assign sclk_rise = edge_hit[PIN_SCLK-1];
  assign cs_rise   = edge_hit[PIN_CSN-1];
  assign rst_fall  = edge_hit[PIN_RSTN-1];
  assign cs_n_s    = pin_s[PIN_CSN];
  assign shift_en  = sclk_rise & ~cs_n_s;

  atten_shift_path #(
    .WORD_W(WORD_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (rst_fall),
    .shift_en(shift_en),
    .din     (pin_s[PIN_DIN]),
    .drive_en(~cs_n_s),
    .word_o  (sreg_word),
    .sdo_o   (ser_dout)
  );

  atten_active_reg #(
    .CODE_W(CODE_W)
  ) u_active (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cs_rise),
    .clear    (rst_fall),
    .load_word(sreg_word[WORD_W-1:RSV_W]),
    .code_o   (atten_code),
    .stb_o    (word_load)
  );
endmodule

// File: rtl/atten_ctrl_slave_chk.sv
module atten_ctrl_slave_chk #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned RSV_W  = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ser_cs_n,
  input logic                    ser_dout,
  input logic [WORD_W-RSV_W-1:0] atten_code,
  input logic                    word_load,
  input logic                    cs_rise,
  input logic                    rst_fall,
  input logic                    cs_n_s,
  input logic [WORD_W-1:0]       sreg_word
);
  assert_code_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_rise && !rst_fall) |=> $stable(atten_code));

  assert_latch_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !rst_fall) |=> (atten_code == $past(sreg_word[WORD_W-1:RSV_W])));

  assert_deselect_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && !rst_fall) |=> $stable(sreg_word));

  assert_sdo_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ser_cs_n, 2) |-> !ser_dout);

  assert_pin_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_fall |=> (atten_code == '0 && sreg_word == '0));

  assert_load_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !rst_fall) |=> word_load);

  assert_strobe_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_load |-> $past(cs_rise));
endmodule

bind atten_ctrl_slave atten_ctrl_slave_chk #(
  .WORD_W(WORD_W),
  .RSV_W (RSV_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_cs_n  (ser_cs_n),
  .ser_dout  (ser_dout),
  .atten_code(atten_code),
  .word_load (word_load),
  .cs_rise   (cs_rise),
  .rst_fall  (rst_fall),
  .cs_n_s    (cs_n_s),
  .sreg_word (sreg_word)
);

// File: tb/atten_ctrl_slave_bench.sv
module atten_ctrl_slave_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_din = 1'b0, ser_cs_n = 1'b1, ser_rst_n = 1'b1;
  logic ser_dout, word_load;
  logic [5:0] atten_code;

  int total = 0, bad = 0, stb_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  atten_ctrl_slave u_atten_ctrl_slave (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_cs_n(ser_cs_n), .ser_rst_n(ser_rst_n), .ser_dout(ser_dout),
    .atten_code(atten_code), .word_load(word_load)
  );

  // behavioural reference: pin history (bit0 newest) and a bit queue
  logic [3:0] h_din, h_clk, h_cs, h_rst;
  bit m_q[$];
  logic [5:0] m_code;
  logic m_stb, m_sdo;
  bit sr, cr, rf;

  always @(posedge clk) begin
    if (!rst_n) begin
      h_din = '0; h_clk = '0; h_cs = '1; h_rst = '1;
      m_q = {};
      for (int i = 0; i < 8; i++) m_q.push_back(1'b0);
      m_code = '0; m_stb = 1'b0; m_sdo = 1'b0;
    end else begin
      sr = h_clk[1] && !h_clk[2];
      cr = h_cs[1] && !h_cs[2];
      rf = !h_rst[1] && h_rst[2];
      m_stb = cr && !rf;
      if (rf) begin
        for (int i = 0; i < 8; i++) m_q[i] = 1'b0;
        m_code = '0;
      end else begin
        if (cr) for (int i = 0; i < 6; i++) m_code[i] = m_q[i+2];
        if (sr && !h_cs[1]) begin
          m_q.push_back(h_din[1]);
          void'(m_q.pop_front());
        end
      end
      h_din = {h_din[2:0], ser_din};
      h_clk = {h_clk[2:0], ser_clk};
      h_cs  = {h_cs[2:0], ser_cs_n};
      h_rst = {h_rst[2:0], ser_rst_n};
      m_sdo = !h_cs[1] && m_q[0];
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4", "code vs model", {26'd0, atten_code}, {26'd0, m_code});
      chk("R6", "sdo vs model", {31'd0, ser_dout}, {31'd0, m_sdo});
      chk("R8", "strobe vs model", {31'd0, word_load}, {31'd0, m_stb});
      if (word_load) stb_cnt++;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(bit b);
    ser_din = b; ser_clk = 1'b0; wait_n(3);
    ser_clk = 1'b1; wait_n(3);
    ser_clk = 1'b0;
  endtask

  task automatic send_word(logic [7:0] w);
    for (int i = 0; i < 8; i++) sbit(w[i]);
  endtask

  task automatic cs_lo();
    ser_cs_n = 1'b0; wait_n(3);
  endtask

  task automatic cs_hi();
    ser_cs_n = 1'b1; wait_n(5);
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  logic [7:0] wa, wb, ws;
  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // R1: reset state
    chk("R1", "code after reset", {26'd0, atten_code}, 32'd0);
    chk("R1", "sdo after reset", {31'd0, ser_dout}, 32'd0);
    chk("R1", "strobe after reset", {31'd0, word_load}, 32'd0);

    // R2 and R4: asymmetric word, code held until select rises
    cs_lo();
    send_word(8'hB5);
    chk("R4", "code before select rise", {26'd0, atten_code}, 32'd0);
    ser_cs_n = 1'b1; wait_n(2);
    chk("R4", "code one edge early", {26'd0, atten_code}, 32'd0);
    wait_n(3);
    chk("R2", "code of 0xB5", {26'd0, atten_code}, 32'h2D);

    // R3: clocks while deselected are ignored
    for (int i = 0; i < 8; i++) sbit(1'b1);
    cs_lo(); cs_hi();
    chk("R3", "code after deselected clocks", {26'd0, atten_code}, 32'h2D);

    // R5: field meaning
    cs_lo(); send_word(8'hFF); cs_hi();
    chk("R5", "code of 0xFF", {26'd0, atten_code}, 32'h3F);
    cs_lo(); send_word(8'h80); cs_hi();
    chk("R5", "code of 0x80", {26'd0, atten_code}, 32'h20);

    // R6: 16-bit daisy burst, first word appears on clocks 9 to 16
    wa = 8'h5C; wb = 8'hE3;
    stb_cnt = 0;
    cs_lo();
    for (int j = 1; j <= 16; j++) begin
      ser_din = (j <= 8) ? wa[j-1] : wb[j-9];
      ser_clk = 1'b0; wait_n(3);
      if (j >= 9) chk("R6", "sdo bit to next part", {31'd0, ser_dout}, {31'd0, wa[j-9]});
      ser_clk = 1'b1; wait_n(3);
    end
    ser_clk = 1'b0;
    cs_hi();
    chk("R2", "code keeps second word", {26'd0, atten_code}, {26'd0, wb[7:2]});
    chk("R6", "sdo quiet when deselected", {31'd0, ser_dout}, 32'd0);
    chk("R8", "one strobe per load", stb_cnt, 32'd1);

    // R9: short word of three bits
    cs_lo(); sbit(1'b1); sbit(1'b0); sbit(1'b1); cs_hi();
    ws = (wb >> 3) | (8'b101 << 5);
    chk("R9", "code after short word", {26'd0, atten_code}, {26'd0, ws[7:2]});

    // R7: device reset pin clears, empty select pulse latches zero
    ser_rst_n = 1'b0; wait_n(5);
    chk("R7", "code after pin reset", {26'd0, atten_code}, 32'd0);
    ser_rst_n = 1'b1; wait_n(3);
    cs_lo(); send_word(8'hFF); ser_rst_n = 1'b0; wait_n(5); ser_rst_n = 1'b1; wait_n(3);
    stb_cnt = 0;
    cs_hi();
    chk("R7", "zero word latched after reset", {26'd0, atten_code}, 32'd0);
    chk("R8", "strobe for empty pulse", stb_cnt, 32'd1);

    wait_n(4);
    finish_run();
  end
endmodule